// File: doc/BRIEF.md
# OUT Endpoint Receive Transfer Terminator

This block sits behind the packet receiver of a device-side OUT endpoint (control or bulk) and owns that endpoint's receive FIFO. The receiver marks the start of each data packet addressed to the endpoint. It then delivers the payload one byte per write strobe. Finally it closes the packet with an end strobe and a good/bad qualifier. The block decides at packet start whether the packet will be taken or refused, and it stores the accepted bytes provisionally. On a good end it commits them. On a bad end it throws them away. One cycle after the end strobe it reports the handshake to return: ACK or NAK.

A transfer is considered finished when a packet shorter than the programmed maximum size arrives. A zero-length packet also finishes it, but only when it comes straight after one or more full-size packets. Once a transfer is finished, the block refuses every further host packet until software acknowledges the end-of-transfer flag. Before doing that, software reads the committed byte count from the fill level and drains the data. Three sticky flags (packet received, transfer ended, fill level above threshold) are combined through a mask into a single interrupt line.

Top module: `out_ep_rx`

## Requirements
- R1: After reset the fill level is 0, all three flags are 0, the interrupt line is low and neither handshake output is high.
- R2: A good packet that is accepted produces a one-cycle `hs_ack` pulse in the cycle after `pkt_end` and sets flag bit 0 (packet received); its bytes become readable in arrival order and the fill level grows by the byte count.
- R3: An accepted good packet with 1 to `max_pkt`-1 bytes sets flag bit 1 (transfer ended).
- R4: An accepted good zero-length packet sets flag bit 1 only when the previous accepted good packet was full size (byte count at least `max_pkt`); otherwise it is acknowledged and sets bit 0 alone.
- R5: While flag bit 1 is set, a good packet is answered with a one-cycle `hs_nak` pulse, stores no bytes and sets no flag.
- R6: A good packet is also answered with NAK and stores nothing when, at its start, the free space (DEPTH minus fill level) is less than `max_pkt`.
- R7: A packet ended with `pkt_good` low produces no handshake, sets no flag and leaves the fill level and FIFO contents as they were at its start.
- R8: Flag bit 2 is set when the fill level changes from at most `lvl_thresh` to above `lvl_thresh`.
- R9: Flags stay set until a 1 is written to the matching bit of `flag_clr`; a flag being set in the same cycle as its clear stays set.
- R10: `irq` is high exactly when some flag bit and the matching `flag_mask` bit are both 1.
- R11: `rd_en` with a non-zero fill level removes the oldest committed byte, which is shown on `rd_data` beforehand; `rd_en` at fill level 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Data packet for this endpoint begins |
| byte_wr | input | 1 | Payload byte strobe |
| byte_data | input | DW | Payload byte |
| pkt_end | input | 1 | Packet finished (never in the same cycle as `byte_wr`) |
| pkt_good | input | 1 | Qualifies `pkt_end`: packet received without error |
| max_pkt | input | CNT_W | Maximum packet size in bytes (1..DEPTH) |
| lvl_thresh | input | CNT_W | Fill-level threshold for flag bit 2 |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| flag_mask | input | 3 | Interrupt enable per flag |
| rd_en | input | 1 | Pop one committed byte |
| rd_data | output | DW | Oldest committed byte |
| fill_level | output | CNT_W | Number of committed bytes held |
| hs_ack | output | 1 | Return ACK for the packet just ended |
| hs_nak | output | 1 | Return NAK for the packet just ended |
| flags | output | 3 | Sticky flags: bit 0 packet received, bit 1 transfer ended, bit 2 level above threshold |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench sweeps every payload length from zero to the maximum packet size for two maximum sizes. Each length is preceded either by a full-size packet or by a short one, so a design that ended transfers on every zero-length packet, or never on a zero-length one, disagrees on the flag. After each ended transfer it sends another packet. A block that kept accepting would show an ACK and a grown fill level where NAK and an unchanged level are due. Corrupted packets are placed between good ones; without rollback of the write pointer, the following read-out sequence is shifted. The bench also fills the FIFO until the space for a full packet is gone, sweeps the threshold across a fixed packet length, and clears a flag in the very cycle it is set.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;
    localparam int FLAG_N  = 3;
    localparam int FL_EOP  = 0;
    localparam int FL_EOT  = 1;
    localparam int FL_LVL  = 2;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_TAKE = 2'd1,
        RX_DROP = 2'd2
    } rx_mode_e;
endpackage

// File: rtl/out_ep_fifo.sv
module out_ep_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    input  logic             commit,
    input  logic             rollback,
    input  logic             rd,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] room,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wr_ptr;   // speculative write position
        logic [AW:0] cm_ptr;   // end of committed data
        logic [AW:0] rd_ptr;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   used;

    assign used  = q.wr_ptr - q.rd_ptr;
    assign full  = (used == (AW+1)'(DEPTH));
    assign level = q.cm_ptr - q.rd_ptr;
    assign room  = CNT_W'(DEPTH) - level;
    assign rdata = mem[q.rd_ptr[AW-1:0]];

    always_comb begin
        d = q;
        if (wr)
            d.wr_ptr = q.wr_ptr + 1'b1;
        if (rd && (level != '0))
            d.rd_ptr = q.rd_ptr + 1'b1;
        if (rollback)
            d.wr_ptr = q.cm_ptr;
        if (commit)
            d.cm_ptr = d.wr_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr)
            mem[q.wr_ptr[AW-1:0]] <= wdata;
    end

    // R6: the packet controller never writes into a full store
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !full);

    // R7: a rollback returns the write position to the committed end
    p_rollback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !commit) |=> (q.wr_ptr == $past(q.cm_ptr)));

    // R11: committed level never exceeds the capacity
    p_level_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));
endmodule

// File: rtl/out_ep_xfer.sv
module out_ep_xfer
    import out_ep_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             byte_wr,
    input  logic             pkt_end,
    input  logic             pkt_good,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             eot_pending,
    input  logic [CNT_W-1:0] room,
    input  logic             fifo_full,
    output logic             fifo_wr,
    output logic             fifo_commit,
    output logic             fifo_rollback,
    output logic             set_eop,
    output logic             set_eot,
    output logic             hs_ack,
    output logic             hs_nak
);
    typedef struct packed {
        rx_mode_e         mode;
        logic [CNT_W-1:0] cnt;
        logic             prev_full;
        logic             hs_ack;
        logic             hs_nak;
    } xfer_st_t;

    xfer_st_t q, d;
    logic     refuse;

    assign refuse = eot_pending || (room < max_pkt);

    always_comb begin
        d             = q;
        d.hs_ack      = 1'b0;
        d.hs_nak      = 1'b0;
        fifo_wr       = 1'b0;
        fifo_commit   = 1'b0;
        fifo_rollback = 1'b0;
        set_eop       = 1'b0;
        set_eot       = 1'b0;
        if (pkt_start) begin
            fifo_rollback = 1'b1;
            d.cnt         = '0;
            d.mode        = refuse ? RX_DROP : RX_TAKE;
        end else if (q.mode != RX_IDLE) begin
            if (byte_wr) begin
                if (q.cnt != '1)
                    d.cnt = q.cnt + 1'b1;
                fifo_wr = (q.mode == RX_TAKE) && !fifo_full;
            end
            if (pkt_end) begin
                d.mode = RX_IDLE;
                if (q.mode == RX_DROP) begin
                    d.hs_nak = pkt_good;
                end else if (pkt_good) begin
                    fifo_commit = 1'b1;
                    d.hs_ack    = 1'b1;
                    set_eop     = 1'b1;
                    if (q.cnt >= max_pkt) begin
                        d.prev_full = 1'b1;
                    end else if ((q.cnt != '0) || q.prev_full) begin
                        set_eot     = 1'b1;
                        d.prev_full = 1'b0;
                    end
                end else begin
                    fifo_rollback = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '{mode: RX_IDLE, cnt: '0, prev_full: 1'b0, hs_ack: 1'b0, hs_nak: 1'b0};
        else
            q <= d;
    end

    assign hs_ack = q.hs_ack;
    assign hs_nak = q.hs_nak;

    // R2: one handshake kind at a time
    p_hs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.hs_ack && q.hs_nak));

    // R5: a refused packet never reports a received packet
    p_nak_no_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.hs_nak |-> !$past(set_eop));

    // R5: a pending transfer end refuses the next packet
    p_eot_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && eot_pending) |=> (q.mode == RX_DROP));
endmodule

// File: rtl/out_ep_irq.sv
module out_ep_irq
    import out_ep_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_eop,
    input  logic              set_eot,
    input  logic [CNT_W-1:0]  level,
    input  logic [CNT_W-1:0]  thresh,
    input  logic [FLAG_N-1:0] clr,
    input  logic [FLAG_N-1:0] mask,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    typedef struct packed {
        logic [FLAG_N-1:0] flags;
        logic              above;
    } irq_st_t;

    irq_st_t           q, d;
    logic [FLAG_N-1:0] set_vec;

    always_comb begin
        d                = q;
        d.above          = (level > thresh);
        set_vec          = '0;
        set_vec[FL_EOP]  = set_eop;
        set_vec[FL_EOT]  = set_eot;
        set_vec[FL_LVL]  = d.above && !q.above;
        d.flags          = (q.flags & ~clr) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign flags = q.flags;
    assign irq   = |(q.flags & mask);

    // R9: a flag without a clear strobe stays set
    for (genvar i = 0; i < FLAG_N; i++) begin : g_sticky
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (q.flags[i] && !clr[i]) |=> q.flags[i]);
    end

    // R8: the level flag only appears while the level is above threshold
    p_lvl_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flags[FL_LVL]) |-> q.above);
endmodule

// File: rtl/out_ep_rx.sv
module out_ep_rx
    import out_ep_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              byte_wr,
    input  logic [DW-1:0]     byte_data,
    input  logic              pkt_end,
    input  logic              pkt_good,
    input  logic [CNT_W-1:0]  max_pkt,
    input  logic [CNT_W-1:0]  lvl_thresh,
    input  logic [FLAG_N-1:0] flag_clr,
    input  logic [FLAG_N-1:0] flag_mask,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    output logic [CNT_W-1:0]  fill_level,
    output logic              hs_ack,
    output logic              hs_nak,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    logic             f_wr, f_commit, f_rollback, f_full;
    logic [CNT_W-1:0] f_room;
    logic             s_eop, s_eot;

    out_ep_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (f_wr),
        .wdata    (byte_data),
        .commit   (f_commit),
        .rollback (f_rollback),
        .rd       (rd_en),
        .rdata    (rd_data),
        .level    (fill_level),
        .room     (f_room),
        .full     (f_full)
    );

    out_ep_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_start     (pkt_start),
        .byte_wr       (byte_wr),
        .pkt_end       (pkt_end),
        .pkt_good      (pkt_good),
        .max_pkt       (max_pkt),
        .eot_pending   (flags[FL_EOT]),
        .room          (f_room),
        .fifo_full     (f_full),
        .fifo_wr       (f_wr),
        .fifo_commit   (f_commit),
        .fifo_rollback (f_rollback),
        .set_eop       (s_eop),
        .set_eot       (s_eot),
        .hs_ack        (hs_ack),
        .hs_nak        (hs_nak)
    );

    out_ep_irq #(.CNT_W(CNT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_eop (s_eop),
        .set_eot (s_eot),
        .level   (fill_level),
        .thresh  (lvl_thresh),
        .clr     (flag_clr),
        .mask    (flag_mask),
        .flags   (flags),
        .irq     (irq)
    );

    // R5: while the transfer end is pending the committed level cannot grow
    p_hold_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags[FL_EOT]) && flags[FL_EOT]) |-> (fill_level <= $past(fill_level)));
endmodule

// File: tb/test_out_ep_rx.sv
module test_out_ep_rx;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_start = 1'b0, byte_wr = 1'b0, pkt_end = 1'b0, pkt_good = 1'b0;
    logic [7:0]    byte_data = '0;
    logic [CW-1:0] max_pkt = 5'd8, lvl_thresh = 5'd5;
    logic [2:0]    flag_clr = '0, flag_mask = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [CW-1:0] fill_level;
    logic          hs_ack, hs_nak, irq;
    logic [2:0]    flags;

    out_ep_rx #(.DW(8), .DEPTH(DEPTH), .CNT_W(CW)) i_out_ep_rx (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .byte_wr(byte_wr),
        .byte_data(byte_data), .pkt_end(pkt_end), .pkt_good(pkt_good),
        .max_pkt(max_pkt), .lvl_thresh(lvl_thresh), .flag_clr(flag_clr),
        .flag_mask(flag_mask), .rd_en(rd_en), .rd_data(rd_data),
        .fill_level(fill_level), .hs_ack(hs_ack), .hs_nak(hs_nak),
        .flags(flags), .irq(irq)
    );

    always #10 clk = ~clk;

    int         n_cmp = 0, n_bad = 0;
    logic [7:0] model [64];
    int         head = 0, cnt = 0;
    logic [7:0] seq = 8'h11;
    logic [2:0] xflags = '0;
    bit         prev_full = 1'b0;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(int n, bit good, bit clr_eop, string tag);
        int  old = cnt;
        int  mps = int'(max_pkt);
        bit  refuse = xflags[1] || ((DEPTH - old) < mps);
        logic [7:0] buf_b [64];
        @(negedge clk) pkt_start = 1'b1;
        @(negedge clk) pkt_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_wr = 1'b1; byte_data = seq; buf_b[i] = seq; seq = seq + 8'd7;
            @(negedge clk);
        end
        byte_wr = 1'b0;
        pkt_end = 1'b1; pkt_good = good; flag_clr = clr_eop ? 3'b001 : 3'b000;
        @(negedge clk);
        pkt_end = 1'b0; pkt_good = 1'b0;
        if (clr_eop) xflags[0] = 1'b0;
        flag_clr = 3'b000;
        chk(tag, int'(hs_ack), (good && !refuse) ? 1 : 0);
        chk(tag, int'(hs_nak), (good && refuse) ? 1 : 0);
        if (good && !refuse) begin
            for (int i = 0; i < n; i++) begin
                model[(head + cnt) % 64] = buf_b[i];
                cnt++;
            end
            xflags[0] = 1'b1;
            if (n >= mps) prev_full = 1'b1;
            else if (n != 0 || prev_full) begin xflags[1] = 1'b1; prev_full = 1'b0; end
            if (old <= int'(lvl_thresh) && cnt > int'(lvl_thresh)) xflags[2] = 1'b1;
        end
        @(negedge clk);
        chk(tag, int'(fill_level), cnt);
        chk(tag, int'(flags), int'(xflags));
    endtask

    task automatic clear(logic [2:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = 3'b000;
        xflags = xflags & ~m;
        chk("R9", int'(flags), int'(xflags));
    endtask

    task automatic drain();
        @(negedge clk);
        while (cnt > 0) begin
            chk("R11", int'(rd_data), int'(model[head]));
            rd_en = 1'b1;
            @(negedge clk);
            head = (head + 1) % 64; cnt--;
        end
        rd_en = 1'b0;
        chk("R11", int'(fill_level), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        flag_mask = 3'b111;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'(fill_level), 0);
        chk("R1", int'(flags), 0);
        chk("R1", int'(irq), 0);
        chk("R1", int'(hs_ack) + int'(hs_nak), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(flags), 0);

        // R4: lone zero-length packet does not end a transfer
        max_pkt = 5'd8;
        send(0, 1'b1, 1'b0, "R4");
        clear(3'b111);

        // R11: read on empty is ignored
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R11", int'(fill_level), 0);

        // length sweep for two maximum sizes, two predecessors
        for (int m = 4; m <= 8; m += 4) begin
            max_pkt = CW'(m);
            for (int pre = 0; pre < 2; pre++) begin
                for (int n = 0; n <= m; n++) begin
                    string tag;
                    drain();
                    clear(3'b111);
                    if (pre == 0) send(1, 1'b1, 1'b0, "R3");
                    else          send(m, 1'b1, 1'b0, "R2");
                    clear(3'b111);
                    // R7: corrupted packet in between
                    send(3, 1'b0, 1'b0, "R7");
                    tag = (n == 0) ? "R4" : ((n < m) ? "R3" : "R2");
                    send(n, 1'b1, 1'b0, tag);
                    if (xflags[1]) begin
                        clear(3'b001);
                        send(2, 1'b1, 1'b0, "R5");
                        send(2, 1'b0, 1'b0, "R7");
                    end
                end
            end
        end
        drain();
        clear(3'b111);

        // R6: fill until a full packet no longer fits
        max_pkt = 5'd8;
        send(8, 1'b1, 1'b0, "R6");
        send(8, 1'b1, 1'b0, "R6");
        send(8, 1'b1, 1'b0, "R6");
        max_pkt = 5'd4;
        drain();
        clear(3'b111);
        send(4, 1'b1, 1'b0, "R6");
        send(4, 1'b1, 1'b0, "R6");
        send(4, 1'b1, 1'b0, "R6");
        send(4, 1'b1, 1'b0, "R6");
        send(4, 1'b1, 1'b0, "R6");
        drain();
        clear(3'b111);

        // R8: threshold sweep with a fixed 4-byte packet
        max_pkt = 5'd8;
        for (int t = 0; t <= 6; t++) begin
            lvl_thresh = CW'(t);
            @(negedge clk);
            send(4, 1'b1, 1'b0, "R8");
            chk("R8", int'(flags[2]), (4 > t) ? 1 : 0);
            drain();
            clear(3'b111);
        end
        lvl_thresh = 5'd5;

        // R9: clear in the same cycle as the set keeps the flag
        send(8, 1'b1, 1'b1, "R9");
        chk("R9", int'(flags[0]), 1);

        // R10: mask sweep
        send(2, 1'b1, 1'b0, "R10");
        for (int mk = 0; mk < 8; mk++) begin
            @(negedge clk) flag_mask = 3'(mk);
            @(negedge clk);
            chk("R10", int'(irq), ((xflags & 3'(mk)) != 3'b000) ? 1 : 0);
        end
        drain();
        clear(3'b111);
        chk("R10", int'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule